// File: doc/BRIEF.md
# Per-Thread Store Queue with Load Forwarding

This block holds the stores of four hardware threads between the execution pipeline and the second-level cache interface. One shared array of 32 entries is divided into four private 8-entry first-in-first-out queues, one per thread. A store enters its thread's queue with no cache tag check. The store leaves toward the L2 interface through a valid/ready request port. It stays in the queue until the L2 side returns an acknowledgement for that thread. Only then is the entry freed, and only then is the store presented on a first-level data cache update port. Stores never allocate cache lines.

Each store carries an ordering flavour. A strongly ordered (TSO) store may issue only when its thread has no other TSO store issued and still unacknowledged. A relaxed (RMO) store has no such limit. Issue within a thread follows queue order, so a blocked TSO store also holds back the stores behind it. A round-robin arbiter chooses among the threads whose next unissued store may go. It is a two-state machine: ARB_IDLE picks a thread and moves to ARB_OFFER. ARB_OFFER holds the request until it is accepted, then returns to ARB_IDLE. Each thread also has a two-state ordering machine. TSO_FREE moves to TSO_BUSY when a TSO store of that thread issues. TSO_BUSY moves back to TSO_FREE when the acknowledgement retires that TSO store.

A load lookup port searches the loading thread's entries in the same cycle. If the youngest entry to the same address overlaps the load's bytes and covers all of them, the load is forwarded that entry's data. If that entry overlaps only part of the load's bytes, the load is told to stall.

Top module: `tsq_top`

## Requirements
- R1: After reset all queues are empty: `ins_ready` is 1 for every thread, `req_valid`, `upd_valid`, `ld_hit` and `ld_stall` are 0.
- R2: A store offered with `ins_valid` is accepted at the clock edge when its thread holds fewer than 8 entries. When the thread holds 8, `ins_ready` is 0 and the store is dropped and is never issued.
- R3: The stores of one thread are issued on the request port in the order they were accepted.
- R4: A store with `ins_tso`=1 is not offered while its thread has a TSO store issued and unacknowledged. A store with `ins_tso`=0 is offered regardless of outstanding TSO stores.
- R5: After thread t is granted, the next grant goes to the first thread in the order t+1, t+2, ... (modulo 4) that has an issuable store.
- R6: While `req_valid` is 1 and `req_ready` is 0, every request output keeps its value into the next cycle.
- R7: `ack_valid` with `ack_tid` retires the oldest issued, unacknowledged store of that thread. In that same cycle it drives `upd_valid`=1 with that store's address, data and byte mask. An acknowledgement for a thread with nothing outstanding is ignored: `upd_valid` stays 0.
- R8: A retired entry is freed: its thread's `ins_ready` returns to 1, and the entry no longer takes part in load lookups.
- R9: A load hits (`ld_hit`=1, `ld_data` = entry data) when the youngest entry of the same thread with the same address and a byte mask overlapping the load mask covers every byte of the load mask. Entries of other threads never match.
- R10: When that youngest overlapping entry covers only part of the load mask, `ld_stall`=1 and `ld_hit`=0. The two are never 1 together.
- R11: A load with no overlapping same-thread entry gives `ld_hit`=0 and `ld_stall`=0.
- R12: `upd_valid` is 1 only in a cycle with an accepted acknowledgement, never on insert or issue.
- R13: In the cycle after a request is accepted (`req_valid` and `req_ready` both 1), `req_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Store insert request |
| ins_tid | input | 2 | Thread of the inserted store |
| ins_tso | input | 1 | 1 = strongly ordered store, 0 = relaxed |
| ins_addr | input | 16 | Doubleword address of the store |
| ins_data | input | 64 | Store data |
| ins_mask | input | 8 | Byte enables of the store |
| ins_ready | output | 1 | Thread `ins_tid` has a free entry |
| ld_valid | input | 1 | Load lookup request |
| ld_tid | input | 2 | Thread of the load |
| ld_addr | input | 16 | Doubleword address of the load |
| ld_mask | input | 8 | Bytes read by the load |
| ld_hit | output | 1 | Load fully served from the queue |
| ld_stall | output | 1 | Load partly overlaps a queued store |
| ld_data | output | 64 | Forwarded data, valid with `ld_hit` |
| req_valid | output | 1 | Store offered to L2 |
| req_ready | input | 1 | L2 side accepts the offer |
| req_tid | output | 2 | Thread of the offered store |
| req_tso | output | 1 | Ordering flavour of the offered store |
| req_addr | output | 16 | Address of the offered store |
| req_data | output | 64 | Data of the offered store |
| req_mask | output | 8 | Byte enables of the offered store |
| ack_valid | input | 1 | Store acknowledgement from L2 |
| ack_tid | input | 2 | Thread being acknowledged |
| upd_valid | output | 1 | L1 data cache update strobe |
| upd_addr | output | 16 | Address of the retired store |
| upd_data | output | 64 | Data of the retired store |
| upd_mask | output | 8 | Byte enables of the retired store |

## Verification
Loads are aimed at addresses where an older store fully covers the load but a younger one covers only part of it. A lookup that picked the oldest match, or ignored coverage, would forward stale data instead of stalling. A thread is filled to its limit and offered one more store. A queue that mishandled fullness would later issue that extra address or overwrite a live entry. Threads with uneven store counts are drained together, so a wrong rotation or a wrong per-thread pointer shows up as a different issue order. Two back-to-back TSO stores followed by a relaxed store show whether the ordering machine blocks only TSO stores and is released by exactly the acknowledgement that retires them. A spurious acknowledgement shows whether an empty thread would produce a bogus cache update.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

    typedef enum logic [0:0] {
        ARB_IDLE,
        ARB_OFFER
    } arb_state_e;

    typedef enum logic [0:0] {
        TSO_FREE,
        TSO_BUSY
    } tso_state_e;

endpackage

// File: rtl/tsq_thread_ctl.sv
module tsq_thread_ctl
    import tsq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req_i,
    input  logic          issue_i,
    input  logic          ack_req_i,
    input  logic          iss_tso_i,
    input  logic          head_tso_i,
    output logic          push_ok_o,
    output logic          ack_ok_o,
    output logic [PW-1:0] tail_o,
    output logic [PW-1:0] iss_o,
    output logic [PW-1:0] head_o,
    output logic [CW-1:0] occ_o,
    output logic          full_o,
    output logic          pend_o,
    output logic          tso_busy_o
);

    logic [PW-1:0] head_q, iss_q, tail_q;
    logic [CW-1:0] occ_q, uniss_q;
    tso_state_e    tso_q, tso_d;

    // Entries issued but not yet acknowledged exist when occ exceeds unissued.
    assign full_o    = (occ_q == CW'(DEPTH));
    assign pend_o    = (uniss_q != '0);
    assign push_ok_o = push_req_i && !full_o;
    assign ack_ok_o  = ack_req_i && (occ_q != uniss_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q  <= '0;
            iss_q   <= '0;
            tail_q  <= '0;
            occ_q   <= '0;
            uniss_q <= '0;
            tso_q   <= TSO_FREE;
        end else begin
            if (push_ok_o) tail_q <= tail_q + 1'b1;
            if (issue_i)   iss_q  <= iss_q + 1'b1;
            if (ack_ok_o)  head_q <= head_q + 1'b1;
            occ_q   <= occ_q + {{(CW-1){1'b0}}, push_ok_o} - {{(CW-1){1'b0}}, ack_ok_o};
            uniss_q <= uniss_q + {{(CW-1){1'b0}}, push_ok_o} - {{(CW-1){1'b0}}, issue_i};
            tso_q   <= tso_d;
        end
    end

    always_comb begin
        tso_d = tso_q;
        unique case (tso_q)
            TSO_FREE: if (issue_i && iss_tso_i)    tso_d = TSO_BUSY;
            TSO_BUSY: if (ack_ok_o && head_tso_i)  tso_d = TSO_FREE;
            default:  tso_d = TSO_FREE;
        endcase
    end

    always_comb begin
        tail_o     = tail_q;
        iss_o      = iss_q;
        head_o     = head_q;
        occ_o      = occ_q;
        tso_busy_o = (tso_q == TSO_BUSY);
    end

endmodule

// File: rtl/tsq_rr_arb.sv
module tsq_rr_arb
    import tsq_pkg::*;
#(
    parameter int NT = 4,
    localparam int TW = $clog2(NT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] elig_i,
    input  logic          ready_i,
    output logic          valid_o,
    output logic [TW-1:0] grant_o,
    output logic          fire_o
);

    arb_state_e    state_q, state_d;
    logic [TW-1:0] last_q, grant_q;
    logic [TW-1:0] pick;
    logic          any_elig;

    // Search starts one past the last granted thread.
    always_comb begin
        any_elig = 1'b0;
        pick     = last_q;
        for (int k = 1; k <= NT; k++) begin
            int idx;
            idx = (int'(last_q) + k) % NT;
            if (!any_elig && elig_i[idx]) begin
                any_elig = 1'b1;
                pick     = TW'(idx);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE:  if (any_elig) state_d = ARB_OFFER;
            ARB_OFFER: if (ready_i)  state_d = ARB_IDLE;
            default:   state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            last_q  <= TW'(NT - 1);
            grant_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ARB_IDLE && any_elig) grant_q <= pick;
            if (state_q == ARB_OFFER && ready_i) last_q <= grant_q;
        end
    end

    always_comb begin
        valid_o = (state_q == ARB_OFFER);
        grant_o = grant_q;
        fire_o  = valid_o && ready_i;
    end

endmodule

// File: rtl/tsq_bypass.sv
module tsq_bypass #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 64,
    localparam int MW = DW / 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = PW + 1
) (
    input  logic          ld_valid_i,
    input  logic [AW-1:0] ld_addr_i,
    input  logic [MW-1:0] ld_mask_i,
    input  logic [PW-1:0] head_i,
    input  logic [CW-1:0] occ_i,
    input  logic [AW-1:0] addr_i [DEPTH],
    input  logic [DW-1:0] data_i [DEPTH],
    input  logic [MW-1:0] mask_i [DEPTH],
    output logic          hit_o,
    output logic          stall_o,
    output logic [DW-1:0] data_o
);

    logic          found;
    logic [MW-1:0] best_mask;
    logic [DW-1:0] best_data;
    logic          covered;

    // Walk from oldest to youngest; a later match replaces an earlier one.
    always_comb begin
        found     = 1'b0;
        best_mask = '0;
        best_data = '0;
        for (int s = 0; s < DEPTH; s++) begin
            int slot;
            slot = (int'(head_i) + s) % DEPTH;
            if (s < int'(occ_i) && addr_i[slot] == ld_addr_i &&
                (mask_i[slot] & ld_mask_i) != '0) begin
                found     = 1'b1;
                best_mask = mask_i[slot];
                best_data = data_i[slot];
            end
        end
    end

    assign covered = ((ld_mask_i & ~best_mask) == '0);
    assign hit_o   = ld_valid_i && found && covered;
    assign stall_o = ld_valid_i && found && !covered;
    assign data_o  = hit_o ? best_data : '0;

endmodule

// File: rtl/tsq_top.sv
module tsq_top
    import tsq_pkg::*;
#(
    parameter int NT    = 4,
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 64,
    localparam int MW  = DW / 8,
    localparam int TW  = $clog2(NT),
    localparam int PW  = $clog2(DEPTH),
    localparam int CW  = PW + 1,
    localparam int TOT = NT * DEPTH,
    localparam int IW  = TW + PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ins_valid,
    input  logic [TW-1:0] ins_tid,
    input  logic          ins_tso,
    input  logic [AW-1:0] ins_addr,
    input  logic [DW-1:0] ins_data,
    input  logic [MW-1:0] ins_mask,
    output logic          ins_ready,
    input  logic          ld_valid,
    input  logic [TW-1:0] ld_tid,
    input  logic [AW-1:0] ld_addr,
    input  logic [MW-1:0] ld_mask,
    output logic          ld_hit,
    output logic          ld_stall,
    output logic [DW-1:0] ld_data,
    output logic          req_valid,
    input  logic          req_ready,
    output logic [TW-1:0] req_tid,
    output logic          req_tso,
    output logic [AW-1:0] req_addr,
    output logic [DW-1:0] req_data,
    output logic [MW-1:0] req_mask,
    input  logic          ack_valid,
    input  logic [TW-1:0] ack_tid,
    output logic          upd_valid,
    output logic [AW-1:0] upd_addr,
    output logic [DW-1:0] upd_data,
    output logic [MW-1:0] upd_mask
);

    // Thread t owns the array slots {t, 0..DEPTH-1}.
    function automatic logic [IW-1:0] slot_at(input logic [TW-1:0] tid,
                                              input logic [PW-1:0] s);
        return {tid, s};
    endfunction

    logic [AW-1:0] e_addr [TOT];
    logic [DW-1:0] e_data [TOT];
    logic [MW-1:0] e_mask [TOT];
    logic          e_tso  [TOT];

    logic [PW-1:0] tail_idx [NT];
    logic [PW-1:0] iss_idx  [NT];
    logic [PW-1:0] head_idx [NT];
    logic [CW-1:0] occ      [NT];
    logic [NT-1:0] full, pend, tso_busy, elig, push_ok, ack_ok;

    logic          arb_valid, arb_fire;
    logic [TW-1:0] arb_grant;

    for (genvar t = 0; t < NT; t++) begin : g_thr
        logic iss_tso, head_tso;
        assign iss_tso  = e_tso[slot_at(TW'(t), iss_idx[t])];
        assign head_tso = e_tso[slot_at(TW'(t), head_idx[t])];
        assign elig[t]  = pend[t] && !(iss_tso && tso_busy[t]);

        tsq_thread_ctl #(.DEPTH(DEPTH)) u_ctl (
            .clk        (clk),
            .rst_n      (rst_n),
            .push_req_i (ins_valid && (ins_tid == TW'(t))),
            .issue_i    (arb_fire && (arb_grant == TW'(t))),
            .ack_req_i  (ack_valid && (ack_tid == TW'(t))),
            .iss_tso_i  (iss_tso),
            .head_tso_i (head_tso),
            .push_ok_o  (push_ok[t]),
            .ack_ok_o   (ack_ok[t]),
            .tail_o     (tail_idx[t]),
            .iss_o      (iss_idx[t]),
            .head_o     (head_idx[t]),
            .occ_o      (occ[t]),
            .full_o     (full[t]),
            .pend_o     (pend[t]),
            .tso_busy_o (tso_busy[t])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TOT; i++) begin
                e_addr[i] <= '0;
                e_data[i] <= '0;
                e_mask[i] <= '0;
                e_tso[i]  <= 1'b0;
            end
        end else begin
            for (int t = 0; t < NT; t++) begin
                if (push_ok[t]) begin
                    e_addr[slot_at(TW'(t), tail_idx[t])] <= ins_addr;
                    e_data[slot_at(TW'(t), tail_idx[t])] <= ins_data;
                    e_mask[slot_at(TW'(t), tail_idx[t])] <= ins_mask;
                    e_tso[slot_at(TW'(t), tail_idx[t])]  <= ins_tso;
                end
            end
        end
    end

    assign ins_ready = !full[ins_tid];

    tsq_rr_arb #(.NT(NT)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .elig_i  (elig),
        .ready_i (req_ready),
        .valid_o (arb_valid),
        .grant_o (arb_grant),
        .fire_o  (arb_fire)
    );

    logic [IW-1:0] req_slot, upd_slot;
    assign req_slot  = slot_at(arb_grant, iss_idx[arb_grant]);
    assign req_valid = arb_valid;
    assign req_tid   = arb_grant;
    assign req_tso   = e_tso[req_slot];
    assign req_addr  = e_addr[req_slot];
    assign req_data  = e_data[req_slot];
    assign req_mask  = e_mask[req_slot];

    assign upd_slot  = slot_at(ack_tid, head_idx[ack_tid]);
    assign upd_valid = ack_ok[ack_tid];
    assign upd_addr  = e_addr[upd_slot];
    assign upd_data  = e_data[upd_slot];
    assign upd_mask  = e_mask[upd_slot];

    logic [AW-1:0] by_addr [DEPTH];
    logic [DW-1:0] by_data [DEPTH];
    logic [MW-1:0] by_mask [DEPTH];

    always_comb begin
        for (int s = 0; s < DEPTH; s++) begin
            by_addr[s] = e_addr[slot_at(ld_tid, PW'(s))];
            by_data[s] = e_data[slot_at(ld_tid, PW'(s))];
            by_mask[s] = e_mask[slot_at(ld_tid, PW'(s))];
        end
    end

    tsq_bypass #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_byp (
        .ld_valid_i (ld_valid),
        .ld_addr_i  (ld_addr),
        .ld_mask_i  (ld_mask),
        .head_i     (head_idx[ld_tid]),
        .occ_i      (occ[ld_tid]),
        .addr_i     (by_addr),
        .data_i     (by_data),
        .mask_i     (by_mask),
        .hit_o      (ld_hit),
        .stall_o    (ld_stall),
        .data_o     (ld_data)
    );

endmodule

// File: rtl/tsq_checker.sv
module tsq_checker #(
    parameter int NT    = 4,
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 64,
    localparam int MW = DW / 8,
    localparam int TW = $clog2(NT),
    localparam int KW = $clog2(DEPTH) + 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ins_valid,
    input logic [TW-1:0] ins_tid,
    input logic          ins_ready,
    input logic          ld_hit,
    input logic          ld_stall,
    input logic          req_valid,
    input logic          req_ready,
    input logic [TW-1:0] req_tid,
    input logic          req_tso,
    input logic [AW-1:0] req_addr,
    input logic [DW-1:0] req_data,
    input logic [MW-1:0] req_mask,
    input logic          ack_valid,
    input logic [TW-1:0] ack_tid,
    input logic          upd_valid,
    input logic [NT-1:0] tso_busy
);

    // Independent per-thread tallies built from port traffic only.
    logic [KW-1:0] held_cnt [NT];
    logic [KW-1:0] outst_cnt [NT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < NT; t++) begin
                held_cnt[t]  <= '0;
                outst_cnt[t] <= '0;
            end
        end else begin
            for (int t = 0; t < NT; t++) begin
                held_cnt[t] <= held_cnt[t]
                    + KW'(ins_valid && ins_ready && ins_tid == TW'(t))
                    - KW'(upd_valid && ack_tid == TW'(t));
                outst_cnt[t] <= outst_cnt[t]
                    + KW'(req_valid && req_ready && req_tid == TW'(t))
                    - KW'(upd_valid && ack_tid == TW'(t));
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_ready) |-> (held_cnt[ins_tid] < KW'(DEPTH))); // R2

    AST_TSO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_tso) |-> !tso_busy[req_tid]); // R4

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_tid) && $stable(req_tso)
            && $stable(req_addr) && $stable(req_data) && $stable(req_mask))); // R6

    AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && outst_cnt[ack_tid] != '0) |-> upd_valid); // R7

    AST_ACK_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (outst_cnt[ack_tid] != '0)); // R7

    AST_HIT_STALL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_hit && ld_stall)); // R10

    AST_UPD_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> ack_valid); // R12

    AST_ISSUE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_valid); // R13

endmodule

bind tsq_top tsq_checker #(.NT(NT), .DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_valid (ins_valid),
    .ins_tid   (ins_tid),
    .ins_ready (ins_ready),
    .ld_hit    (ld_hit),
    .ld_stall  (ld_stall),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_tid   (req_tid),
    .req_tso   (req_tso),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .req_mask  (req_mask),
    .ack_valid (ack_valid),
    .ack_tid   (ack_tid),
    .upd_valid (upd_valid),
    .tso_busy  (tso_busy)
);

// File: tb/tsq_top_tb.sv
module tsq_top_tb_top;

    localparam int CLK_PERIOD = 10;

    localparam logic [63:0] DA = 64'h1111_2222_3333_00A1;
    localparam logic [63:0] DB = 64'h4444_5555_6666_00B2;
    localparam logic [63:0] DC = 64'h7777_8888_9999_00C3;
    localparam logic [63:0] DD = 64'hAAAA_BBBB_CCCC_00D4;
    localparam logic [63:0] DE = 64'hDDDD_EEEE_FFFF_00E5;
    localparam logic [63:0] DF = 64'h0123_4567_89AB_00F6;

    // {tid[2], addr[16], mask[8], exp_hit, exp_stall, exp_data[64]}
    localparam int NV = 10;
    localparam logic [91:0] BYP_VEC [NV] = '{
        {2'd0, 16'h0010, 8'hFF, 1'b0, 1'b1, 64'h0},  // younger partial -> stall
        {2'd0, 16'h0010, 8'hF0, 1'b1, 1'b0, DC},     // youngest covers
        {2'd0, 16'h0020, 8'h0F, 1'b1, 1'b0, DB},
        {2'd0, 16'h0020, 8'h03, 1'b1, 1'b0, DB},
        {2'd0, 16'h0020, 8'h30, 1'b0, 1'b0, 64'h0},  // no byte overlap
        {2'd0, 16'h0020, 8'hFF, 1'b0, 1'b1, 64'h0},
        {2'd1, 16'h0010, 8'hFF, 1'b1, 1'b0, DD},
        {2'd2, 16'h0030, 8'hFF, 1'b1, 1'b0, DF},     // youngest of two full
        {2'd3, 16'h0010, 8'hFF, 1'b0, 1'b0, 64'h0},  // other threads invisible
        {2'd0, 16'h0040, 8'hFF, 1'b0, 1'b0, 64'h0}
    };

    localparam int NE = 14;
    localparam logic [1:0] EXP_TID [NE] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd2, 2'd3,
                                            2'd0, 2'd3, 2'd3, 2'd3, 2'd3, 2'd3, 2'd3};
    localparam logic [15:0] EXP_ADDR [NE] = '{16'h10, 16'h10, 16'h30, 16'h100, 16'h20,
                                              16'h30, 16'h101, 16'h10, 16'h102, 16'h103,
                                              16'h104, 16'h105, 16'h106, 16'h107};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0;
    logic [1:0]  ins_tid = '0;
    logic        ins_tso = 1'b0;
    logic [15:0] ins_addr = '0;
    logic [63:0] ins_data = '0;
    logic [7:0]  ins_mask = '0;
    logic        ins_ready;
    logic        ld_valid = 1'b0;
    logic [1:0]  ld_tid = '0;
    logic [15:0] ld_addr = '0;
    logic [7:0]  ld_mask = '0;
    logic        ld_hit, ld_stall;
    logic [63:0] ld_data;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [1:0]  req_tid;
    logic        req_tso;
    logic [15:0] req_addr;
    logic [63:0] req_data;
    logic [7:0]  req_mask;
    logic        ack_valid = 1'b0;
    logic [1:0]  ack_tid = '0;
    logic        upd_valid;
    logic [15:0] upd_addr;
    logic [63:0] upd_data;
    logic [7:0]  upd_mask;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tsq_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_tid(ins_tid), .ins_tso(ins_tso),
        .ins_addr(ins_addr), .ins_data(ins_data), .ins_mask(ins_mask),
        .ins_ready(ins_ready),
        .ld_valid(ld_valid), .ld_tid(ld_tid), .ld_addr(ld_addr), .ld_mask(ld_mask),
        .ld_hit(ld_hit), .ld_stall(ld_stall), .ld_data(ld_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_tid(req_tid),
        .req_tso(req_tso), .req_addr(req_addr), .req_data(req_data),
        .req_mask(req_mask),
        .ack_valid(ack_valid), .ack_tid(ack_tid),
        .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_data(upd_data),
        .upd_mask(upd_mask)
    );

    // Issue monitor and stray-update monitor.
    logic        mon_en = 1'b0;
    int          seen_n = 0;
    logic [1:0]  seen_tid [32];
    logic [15:0] seen_addr [32];
    int          stray_upd = 0;

    always @(negedge clk) begin
        if (mon_en && req_valid && req_ready && seen_n < 32) begin
            seen_tid[seen_n]  <= req_tid;
            seen_addr[seen_n] <= req_addr;
            seen_n <= seen_n + 1;
        end
        if (rst_n && upd_valid && !ack_valid) stray_upd <= stray_upd + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic insert(input logic [1:0] tid, input logic tso, input logic [15:0] a,
                          input logic [63:0] d, input logic [7:0] m);
        @(posedge clk);
        #1;
        ins_valid = 1'b1; ins_tid = tid; ins_tso = tso;
        ins_addr = a; ins_data = d; ins_mask = m;
        @(posedge clk);
        #1 ins_valid = 1'b0;
    endtask

    task automatic lookup(input logic [1:0] tid, input logic [15:0] a, input logic [7:0] m);
        @(posedge clk);
        #1;
        ld_valid = 1'b1; ld_tid = tid; ld_addr = a; ld_mask = m;
        @(negedge clk);
    endtask

    // Waits for an offer, accepts it, returns what was offered.
    task automatic issue_one(output logic [1:0] tid, output logic [15:0] a);
        int waited = 0;
        @(negedge clk);
        while (!req_valid && waited < 50) begin
            @(negedge clk);
            waited++;
        end
        tid = req_tid;
        a = req_addr;
        req_ready = 1'b1;
        @(posedge clk);
        #1 req_ready = 1'b0;
        @(negedge clk);
        chk(!req_valid, "R13 no offer right after acceptance", 64'(req_valid), 64'h0);
    endtask

    task automatic ack(input logic [1:0] tid, output logic v, output logic [15:0] a,
                       output logic [63:0] d, output logic [7:0] m);
        @(posedge clk);
        #1;
        ack_valid = 1'b1; ack_tid = tid;
        @(negedge clk);
        v = upd_valid; a = upd_addr; d = upd_data; m = upd_mask;
        @(posedge clk);
        #1 ack_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [1:0]  t;
        logic [15:0] a;
        logic        v;
        logic [63:0] d;
        logic [7:0]  m;
        logic [1:0]  h_tid;
        logic [15:0] h_addr;
        logic [63:0] h_data;

        do_reset();
        @(negedge clk);
        // R1 reset state
        for (int i = 0; i < 4; i++) begin
            ins_tid = 2'(i);
            #1 chk(ins_ready, "R1 ins_ready after reset", 64'(ins_ready), 64'h1);
        end
        chk(!req_valid, "R1 req_valid after reset", 64'(req_valid), 64'h0);
        chk(!upd_valid, "R1 upd_valid after reset", 64'(upd_valid), 64'h0);
        ld_valid = 1'b1; ld_tid = 2'd0; ld_addr = 16'h10; ld_mask = 8'hFF;
        #1 chk(!ld_hit && !ld_stall, "R1 R11 empty lookup",
               {62'h0, ld_hit, ld_stall}, 64'h0);
        ld_valid = 1'b0;

        // Fill phase with the L2 side not ready.
        insert(2'd0, 1'b0, 16'h10, DA, 8'hFF);
        insert(2'd0, 1'b0, 16'h20, DB, 8'h0F);
        insert(2'd0, 1'b0, 16'h10, DC, 8'hF0);
        insert(2'd1, 1'b0, 16'h10, DD, 8'hFF);
        insert(2'd2, 1'b0, 16'h30, DE, 8'hFF);
        insert(2'd2, 1'b0, 16'h30, DF, 8'hFF);
        for (int i = 0; i < 8; i++)
            insert(2'd3, 1'b0, 16'h100 + 16'(i), 64'h3300 + 64'(i), 8'hFF);
        @(negedge clk);
        ins_tid = 2'd3;
        #1 chk(!ins_ready, "R2 ready low when thread holds 8", 64'(ins_ready), 64'h0);
        ins_tid = 2'd0;
        #1 chk(ins_ready, "R2 other thread still ready", 64'(ins_ready), 64'h1);
        insert(2'd3, 1'b0, 16'h1FF, 64'hDEAD, 8'hFF);  // must be dropped

        // R12 no update from insert; R6 offer holds while not ready.
        @(negedge clk);
        chk(stray_upd == 0, "R12 no update on insert", 64'(stray_upd), 64'h0);
        chk(req_valid && req_tid == 2'd0 && req_addr == 16'h10 && req_data == DA,
            "R6 first offer is thread 0 oldest", {req_tid, req_addr}, {2'd0, 16'h10});
        h_tid = req_tid; h_addr = req_addr; h_data = req_data;
        repeat (3) @(negedge clk);
        chk(req_valid && req_tid == h_tid && req_addr == h_addr && req_data == h_data,
            "R6 offer stable while stalled", req_data, h_data);

        // Table-driven bypass lookups (R9 R10 R11).
        for (int i = 0; i < NV; i++) begin
            lookup(BYP_VEC[i][91:90], BYP_VEC[i][89:74], BYP_VEC[i][73:66]);
            chk(ld_hit == BYP_VEC[i][65], "R9 bypass hit", 64'(ld_hit), 64'(BYP_VEC[i][65]));
            chk(ld_stall == BYP_VEC[i][64], "R10 partial stall",
                64'(ld_stall), 64'(BYP_VEC[i][64]));
            if (BYP_VEC[i][65])
                chk(ld_data == BYP_VEC[i][63:0], "R9 forwarded data",
                    ld_data, BYP_VEC[i][63:0]);
        end
        ld_valid = 1'b0;

        // Drain all with ready held high (R2 R3 R5 R12).
        @(posedge clk);
        #1 mon_en = 1'b1; req_ready = 1'b1;
        repeat (60) @(posedge clk);
        #1 req_ready = 1'b0;
        @(negedge clk);
        mon_en = 1'b0;
        chk(seen_n == NE, "R2 count issued, extra store dropped", 64'(seen_n), 64'(NE));
        for (int i = 0; i < NE; i++) begin
            if (i < seen_n)
                chk(seen_tid[i] == EXP_TID[i] && seen_addr[i] == EXP_ADDR[i],
                    "R3 R5 issue order", {seen_tid[i], seen_addr[i]},
                    {EXP_TID[i], EXP_ADDR[i]});
        end
        chk(stray_upd == 0, "R12 no update on issue", 64'(stray_upd), 64'h0);

        // Acknowledgements (R7 R8).
        ack(2'd0, v, a, d, m);
        chk(v && a == 16'h10 && d == DA && m == 8'hFF, "R7 ack retires oldest",
            d, DA);
        ack(2'd0, v, a, d, m);
        chk(v && a == 16'h20 && d == DB && m == 8'h0F, "R7 second ack", d, DB);
        ack(2'd1, v, a, d, m);
        chk(v && d == DD, "R7 thread 1 ack", d, DD);
        ack(2'd1, v, a, d, m);
        chk(!v, "R7 spurious ack ignored", 64'(v), 64'h0);
        lookup(2'd1, 16'h10, 8'hFF);
        chk(!ld_hit && !ld_stall, "R8 freed entry not forwarded",
            {62'h0, ld_hit, ld_stall}, 64'h0);
        lookup(2'd0, 16'h10, 8'hF0);
        chk(ld_hit && ld_data == DC, "R9 remaining entry still forwards", ld_data, DC);
        ld_valid = 1'b0;
        for (int i = 0; i < 8; i++) ack(2'd3, v, a, d, m);
        chk(v && a == 16'h107, "R7 last thread 3 ack", 64'(a), 64'h107);
        @(negedge clk);
        ins_tid = 2'd3;
        #1 chk(ins_ready, "R8 ready returns after acks", 64'(ins_ready), 64'h1);

        // Ordering flavours (R4).
        do_reset();
        insert(2'd0, 1'b1, 16'h50, 64'h50, 8'hFF);
        insert(2'd0, 1'b1, 16'h51, 64'h51, 8'hFF);
        insert(2'd0, 1'b0, 16'h52, 64'h52, 8'hFF);
        insert(2'd1, 1'b1, 16'h60, 64'h60, 8'hFF);
        issue_one(t, a);
        chk(t == 2'd0 && a == 16'h50, "R4 first TSO issues", {t, a}, {2'd0, 16'h50});
        issue_one(t, a);
        chk(t == 2'd1 && a == 16'h60, "R4 blocked TSO skipped", {t, a}, {2'd1, 16'h60});
        v = 1'b0;
        repeat (5) begin
            @(negedge clk);
            v = v | req_valid;
        end
        chk(!v, "R4 no offer while TSO outstanding", 64'(v), 64'h0);
        ack(2'd0, v, a, d, m);
        chk(v && a == 16'h50, "R7 TSO ack update", 64'(a), 64'h50);
        issue_one(t, a);
        chk(t == 2'd0 && a == 16'h51, "R4 TSO after ack", {t, a}, {2'd0, 16'h51});
        issue_one(t, a);
        chk(t == 2'd0 && a == 16'h52, "R4 relaxed not limited", {t, a}, {2'd0, 16'h52});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule